// File: doc/BRIEF.md
# E1 Double-Frame Overhead Capture

This block sits on the receive side of an E1 framer, behind the frame aligner. The aligner supplies the recovered serial data, a strobe that is high on each time-slot-0 bit position, and a qualifier that says whether the current frame carries the frame alignment word (align frame) or not (non-align frame). The block collects the eight time-slot-0 bits of every frame into a byte. The first bit received becomes the most significant bit.

The two bytes of a double frame go to the host as one coherent pair. A non-align byte is first held in a hidden shadow register. When the next align byte is complete, the align byte and the shadowed non-align byte are copied into the host-visible registers on the same clock edge. A sticky flag then tells the host that a fresh pair is ready. The host has one double-frame period to read the pair before the next publish overwrites it. It clears the flag by writing a 1 to the flag's bit.

Top module: `e1_dframe_capture`

## Requirements
- R1: Captured bytes hold the received bits unaltered, with no filtering. The first strobed bit of a byte lands in bit 7 and the last in bit 0. For a correctly aligned align frame, bit 7 is the international bit and bits 6..0 read 0011011.
- R2: `af_byte` and `naf_byte` change only on the clock edge that samples the eighth strobed bit of an align frame. They hold their values on every other edge.
- R3: On that publish edge, `af_byte` takes the align byte just completed. `naf_byte` takes the most recent non-align byte completed before it. If no non-align byte arrived in between, the previous shadow value is published again.
- R4: Completing a non-align byte changes no host-visible output. That byte becomes visible only at the next publish.
- R5: `af_new` is 1 after every publish edge.
- R6: `af_new` stays at 1 until a host write (`host_wr`=1) with `host_wdata`=1 clears it. A write with `host_wdata`=0 leaves it unchanged.
- R7: When a publish and a clearing write fall in the same cycle, the publish wins and `af_new` remains 1.
- R8: After reset, `af_byte`, `naf_byte` and `af_new` are all 0.
- R9: A byte is classed as align or non-align by the value of `ts0_align` at its first strobed bit. Changes of `ts0_align` later in that byte have no effect.
- R10: Cycles with `ts0_stb`=0 capture nothing, and `rx_bit` is ignored in them. A byte may be spread over strobed bits with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered serial receive data |
| ts0_stb | input | 1 | High on each time-slot-0 bit position |
| ts0_align | input | 1 | 1 when the current frame is an align frame |
| host_wr | input | 1 | Host write strobe to the status flag |
| host_wdata | input | 1 | Written value for the flag bit; 1 clears it |
| af_byte | output | 8 | Published align-frame time-slot-0 byte |
| naf_byte | output | 8 | Published non-align-frame time-slot-0 byte |
| af_new | output | 1 | Sticky flag: a new pair has been published |

## Verification
The bench targets these cases:
- Two align frames in a row. A design that cleared or skipped the shadow would publish a wrong non-align byte.
- A qualifier that flips after the first bit of a byte. Sampling it late would publish a non-align byte or hide an align byte.
- Idle cycles inside a byte carrying random data. A design that shifted on every clock would scramble the byte.
- A clearing write that lands on the publish edge, and a write of 0 to the flag. Getting the priority wrong loses a publish notice; decoding the data wrongly clears the flag.

// File: rtl/e1dfc_pkg.sv
package e1dfc_pkg;

  localparam int TS0_W = 8;

  typedef logic [TS0_W-1:0] ts0_byte_t;

  // a finished byte publishes the pair only when it came from an align frame
  function automatic logic publish_now(input logic byte_done, input logic byte_is_align);
    return byte_done & byte_is_align;
  endfunction

  // a finished non-align byte is parked in the shadow
  function automatic logic park_now(input logic byte_done, input logic byte_is_align);
    return byte_done & ~byte_is_align;
  endfunction

  // host clear request: a write carrying a one in the flag bit
  function automatic logic clear_request(input logic wr, input logic wdata);
    return wr & wdata;
  endfunction

endpackage

// File: rtl/e1dfc_ts0_shift.sv
module e1dfc_ts0_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit,
  input  logic         stb,
  input  logic         align_in,
  output logic         byte_done,
  output logic         byte_is_align,
  output logic [W-1:0] byte_out
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-2:0]     sr_q;
  logic             al_q;
  logic             first_bit;
  logic             last_bit;

  assign first_bit     = stb && (cnt_q == '0);
  assign last_bit      = stb && (cnt_q == LAST_IDX);
  assign byte_out      = {sr_q, rx_bit};
  assign byte_done     = last_bit;
  assign byte_is_align = al_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      al_q  <= 1'b0;
    end else if (stb) begin
      sr_q  <= byte_out[W-2:0];
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      if (first_bit) al_q <= align_in;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(sr_q) && $stable(cnt_q))); // R10

  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (cnt_q != '0)) |=> $stable(al_q)); // R9

endmodule

// File: rtl/e1dfc_pair_regs.sv
module e1dfc_pair_regs
  import e1dfc_pkg::*;
#(
  parameter int W = TS0_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_done,
  input  logic         byte_is_align,
  input  logic [W-1:0] byte_in,
  output logic         pub_evt,
  output logic [W-1:0] af_q,
  output logic [W-1:0] naf_q
);
  logic [W-1:0] shad_q;
  logic         park_evt;

  assign pub_evt  = publish_now(byte_done, byte_is_align);
  assign park_evt = park_now(byte_done, byte_is_align);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q   <= '0;
      naf_q  <= '0;
      shad_q <= '0;
    end else if (pub_evt) begin
      af_q  <= byte_in;
      naf_q <= shad_q;
    end else if (park_evt) begin
      shad_q <= byte_in;
    end
  end

  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_evt |=> ($stable(af_q) && $stable(naf_q))); // R2

  AST_PUB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pub_evt |=> (af_q == $past(byte_in))); // R3

  AST_SHADOW_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    park_evt |=> ($stable(naf_q) && $stable(af_q))); // R4

endmodule

// File: rtl/e1dfc_status_flag.sv
module e1dfc_status_flag
  import e1dfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic host_wr,
  input  logic host_wdata,
  output logic flag_q
);
  logic clr_evt;

  assign clr_evt = clear_request(host_wr, host_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag_q); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && set_evt) |=> flag_q); // R7

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R5

endmodule

// File: rtl/e1_dframe_capture.sv
module e1_dframe_capture
  import e1dfc_pkg::*;
#(
  parameter int TS0_BITS = TS0_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_bit,
  input  logic                ts0_stb,
  input  logic                ts0_align,
  input  logic                host_wr,
  input  logic                host_wdata,
  output logic [TS0_BITS-1:0] af_byte,
  output logic [TS0_BITS-1:0] naf_byte,
  output logic                af_new
);
  logic                byte_done;
  logic                byte_is_align;
  logic [TS0_BITS-1:0] cap_byte;
  logic                pub_evt;

  e1dfc_ts0_shift #(.W(TS0_BITS)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_bit        (rx_bit),
    .stb           (ts0_stb),
    .align_in      (ts0_align),
    .byte_done     (byte_done),
    .byte_is_align (byte_is_align),
    .byte_out      (cap_byte)
  );

  e1dfc_pair_regs #(.W(TS0_BITS)) u_pair (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_done     (byte_done),
    .byte_is_align (byte_is_align),
    .byte_in       (cap_byte),
    .pub_evt       (pub_evt),
    .af_q          (af_byte),
    .naf_q         (naf_byte)
  );

  e1dfc_status_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (pub_evt),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .flag_q     (af_new)
  );

  AST_PUB_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_is_align) |=> af_new); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (af_byte == '0 && naf_byte == '0 && !af_new)); // R8

endmodule

// File: tb/e1_dframe_capture_bench.sv
module e1_dframe_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0;
  logic       ts0_stb = 1'b0;
  logic       ts0_align = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_wdata = 1'b0;
  logic [7:0] af_byte;
  logic [7:0] naf_byte;
  logic       af_new;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  e1_dframe_capture u_e1_dframe_capture (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .ts0_stb(ts0_stb),
    .ts0_align(ts0_align), .host_wr(host_wr), .host_wdata(host_wdata),
    .af_byte(af_byte), .naf_byte(naf_byte), .af_new(af_new)
  );

  // behavioural reference: a bit queue and plain byte variables
  bit         bq[$];
  bit         m_cls = 0;
  logic [7:0] m_af = 0, m_naf = 0, m_sh = 0;
  bit         m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_af = 0; m_naf = 0; m_sh = 0; m_flag = 0; bq.delete();
    end else begin
      bit pub;
      pub = 0;
      if (ts0_stb) begin
        if (bq.size() == 0) m_cls = ts0_align;
        bq.push_back(rx_bit);
        if (bq.size() == 8) begin
          logic [7:0] b;
          for (int i = 0; i < 8; i++) b[7-i] = bq[i];
          bq.delete();
          if (m_cls) begin m_naf = m_sh; m_af = b; pub = 1; end
          else m_sh = b;
        end
      end
      if (pub) m_flag = 1;
      else if (host_wr && host_wdata) m_flag = 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R1 R3 af_byte vs model", af_byte, m_af);
      chk("R3 R4 naf_byte vs model", naf_byte, m_naf);
      chk("R5 R6 R7 af_new vs model", {7'd0, af_new}, {7'd0, m_flag});
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !ended) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      finish_run();
    end
  end

  // flip: qualifier inverted after the first bit; gaps: idle cycle after each bit
  task automatic send_byte(input logic [7:0] b, input bit al, input bit flip,
                           input bit gaps, input bit clr_last);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ts0_stb = 1; rx_bit = b[i];
      ts0_align = (flip && i != 7) ? ~al : al;
      host_wr = (i == 0) ? clr_last : 1'b0;
      host_wdata = host_wr;
      if (gaps && i != 0) begin
        @(negedge clk);
        ts0_stb = 0; rx_bit = $urandom; ts0_align = $urandom;
      end
    end
    @(negedge clk);
    ts0_stb = 0; host_wr = 0; host_wdata = 0; rx_bit = $urandom;
    for (int k = 0; k < 3; k++) @(negedge clk);
  endtask

  task automatic host_write(input bit d);
    @(negedge clk); host_wr = 1; host_wdata = d;
    @(negedge clk); host_wr = 0; host_wdata = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 af_byte in reset", af_byte, 8'h00);
    chk("R8 naf_byte in reset", naf_byte, 8'h00);
    chk("R8 af_new in reset", {7'd0, af_new}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R8 af_new after reset", {7'd0, af_new}, 8'h00);

    send_byte(8'h5A, 0, 0, 0, 0);
    chk("R4 non-align hidden af", af_byte, 8'h00);
    chk("R4 non-align hidden naf", naf_byte, 8'h00);
    chk("R4 no flag on non-align", {7'd0, af_new}, 8'h00);

    send_byte(8'h9B, 1, 0, 0, 0);
    chk("R1 align byte Si=1 FAS 0011011", af_byte, 8'h9B);
    chk("R3 paired non-align byte", naf_byte, 8'h5A);
    chk("R5 flag after publish", {7'd0, af_new}, 8'h01);

    host_write(0);
    chk("R6 write of 0 keeps flag", {7'd0, af_new}, 8'h01);
    host_write(1);
    chk("R6 write of 1 clears flag", {7'd0, af_new}, 8'h00);

    send_byte(8'hC3, 0, 0, 1, 0);
    send_byte(8'h1B, 1, 0, 1, 0);
    chk("R10 gapped align byte", af_byte, 8'h1B);
    chk("R10 gapped non-align byte", naf_byte, 8'hC3);

    send_byte(8'h9B, 1, 1, 0, 0);
    chk("R9 class taken at first bit (align)", af_byte, 8'h9B);
    send_byte(8'h7E, 0, 1, 0, 0);
    chk("R9 class taken at first bit (non-align) af", af_byte, 8'h9B);
    chk("R9 class taken at first bit (non-align) naf", naf_byte, 8'hC3);

    send_byte(8'h11, 1, 0, 0, 0);
    chk("R3 first of two aligns naf", naf_byte, 8'h7E);
    send_byte(8'h22, 1, 0, 0, 0);
    chk("R3 second align af", af_byte, 8'h22);
    chk("R3 shadow republished", naf_byte, 8'h7E);

    host_write(1);
    chk("R6 cleared before collision", {7'd0, af_new}, 8'h00);
    send_byte(8'h9B, 1, 0, 0, 1);
    chk("R7 publish beats clear", {7'd0, af_new}, 8'h01);

    for (int n = 0; n < 300; n++) begin
      send_byte(8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) == 0) host_write(1'($urandom));
    end

    finish_run();
  end
endmodule